// File: doc/BRIEF.md
# Double-Buffered Isochronous Receive Buffer

This block stores incoming packets for one isochronous OUT endpoint. Because an isochronous endpoint never retries, a packet must find room the moment it arrives. The buffer therefore has two packet slots. A packet can land in one slot while the consumer is still draining the other, which covers the case where one packet arrives late in a frame and the next arrives early in the following frame.

The write side takes a byte stream with start-of-packet, end-of-packet and CRC-status strobes. The read side presents the oldest complete packet as a byte count and a byte output. The consumer steps through the bytes with a read enable, then releases the slot by writing a zero to the ready bit of the status word.

A packet that finds no free slot is discarded and sets a sticky overrun flag. A packet with a bad CRC is still stored, and it sets a sticky data-error flag. Every stored packet produces a one-cycle interrupt pulse.

Top module: `iso_rx_buffer`

## Requirements
- R1: The block holds two complete packets at once. A second packet is accepted and stored while the first is still unreleased, and neither packet's bytes are disturbed.
- R2: status_o bit 0 (ready) is 1 from the cycle after the end-of-packet beat of a stored packet until that packet is released. status_o bit 1 always reads 0.
- R3: rd_data shows the oldest held packet's bytes in arrival order, starting at byte 0. Each rd_en advances by one byte. rd_en is ignored while ready is 0 or once all bytes of the packet have been read.
- R4: rd_len gives the byte count of the oldest held packet, and reads 0 while ready is 0. Bytes beyond SLOT_BYTES in one packet are discarded, so the count saturates at SLOT_BYTES.
- R5: A start-of-packet beat that finds both slots occupied (held, or being filled) causes that whole packet to be discarded. Both slots keep their contents, and status_o bit 2 (overrun) is 1 from the next cycle.
- R6: A packet whose end-of-packet beat carries wr_crc_err is still stored and raises ready. status_o bit 3 (data error) is 1 from the next cycle.
- R7: irq_o pulses for exactly one cycle, in the cycle after the end-of-packet beat of every stored packet, including packets with a CRC error. A discarded packet gives no pulse.
- R8: A csr_wr with csr_wdata bit 0 at 0 releases the oldest held packet. If a second packet is held, ready stays 1 and that packet is presented from byte 0. Slot occupancy for a start-of-packet beat in the same cycle is judged before the release takes effect.
- R9: After reset, status_o and irq_o are 0 and both slots are free.
- R10: Overrun and data error stay set until a csr_wr writes 0 to the matching bit (bit 2 or bit 3). A new event in the same cycle as the clear wins. Writing 1 leaves the bit unchanged.
- R11: A start-of-packet beat that arrives while an accepted packet is still open restarts that packet in the same slot. Its earlier bytes are dropped, and it does not count as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte valid; qualifies all write strobes |
| wr_sop | input | 1 | Beat is the first byte of a packet |
| wr_eop | input | 1 | Beat is the last byte of a packet |
| wr_crc_err | input | 1 | CRC failed; sampled on the end-of-packet beat |
| wr_data | input | DATA_W | Packet byte |
| rd_en | input | 1 | Advance to the next byte of the oldest packet |
| rd_data | output | DATA_W | Current byte of the oldest packet |
| rd_len | output | $clog2(SLOT_BYTES+1) | Byte count of the oldest packet, 0 when none |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 4 | Status write data (bits 0, 2, 3 act on a zero) |
| status_o | output | 4 | {data error, overrun, 0, ready} |
| irq_o | output | 1 | One-cycle pulse per stored packet |

## Verification
A wrong slot state shows up at the ports within one cycle of the next release or start-of-packet beat. The symptoms are ready staying high with no packet behind it, a wrong rd_len, or an overrun raised while a slot is still free. A wrong read pointer or head index shows up at once as a mismatched rd_data byte. The bench's reference model tracks packets as queues and compares status, interrupt, length and the current byte on every clock, so any such divergence is caught in the cycle it first reaches a port.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

  // Occupancy of one packet slot
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_FILL = 2'd1,
    SLOT_FULL = 2'd2
  } slot_st_e;

  // Status word bit positions
  localparam int ST_W       = 4;
  localparam int ST_READY   = 0;
  localparam int ST_OVERRUN = 2;
  localparam int ST_DATAERR = 3;

endpackage

// File: rtl/iso_rx_slot_mem.sv
module iso_rx_slot_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/iso_rx_wr_ctrl.sv
module iso_rx_wr_ctrl #(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 1024,
  parameter int NSLOT      = 2,
  parameter int AW         = $clog2(SLOT_BYTES),
  parameter int LEN_W      = $clog2(SLOT_BYTES + 1),
  parameter int IDX_W      = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              wr_crc_err,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NSLOT-1:0]  slot_free,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [IDX_W-1:0]  wr_slot,
  output logic              alloc,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len,
  output logic              commit_err,
  output logic              ovr_evt
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(SLOT_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

  logic             act_q, act_n;
  logic             drop_q, drop_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [IDX_W-1:0] tail_q, tail_n;
  logic [IDX_W-1:0] tail_nxt;

  assign tail_nxt = (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;

  always_comb begin
    act_n    = act_q;
    drop_n   = drop_q;
    len_n    = len_q;
    tail_n   = tail_q;
    mem_we   = 1'b0;
    mem_addr = len_q[AW-1:0];
    alloc    = 1'b0;
    commit   = 1'b0;
    ovr_evt  = 1'b0;
    if (wr_valid && wr_sop) begin
      if (act_q && !drop_q) begin
        // restart the open packet in its own slot
        mem_we   = 1'b1;
        mem_addr = '0;
        len_n    = LEN_W'(1);
        if (wr_eop) begin
          commit = 1'b1;
          act_n  = 1'b0;
          tail_n = tail_nxt;
        end
      end else if (slot_free[tail_q]) begin
        alloc    = 1'b1;
        mem_we   = 1'b1;
        mem_addr = '0;
        len_n    = LEN_W'(1);
        drop_n   = 1'b0;
        if (wr_eop) begin
          commit = 1'b1;
          act_n  = 1'b0;
          tail_n = tail_nxt;
        end else begin
          act_n  = 1'b1;
        end
      end else begin
        ovr_evt = 1'b1;
        drop_n  = 1'b1;
        act_n   = !wr_eop;
      end
    end else if (wr_valid && act_q) begin
      if (!drop_q) begin
        if (len_q < CAP) begin
          mem_we = 1'b1;
          len_n  = len_q + 1'b1;
        end
        if (wr_eop) begin
          commit = 1'b1;
          act_n  = 1'b0;
          tail_n = tail_nxt;
        end
      end else if (wr_eop) begin
        act_n  = 1'b0;
        drop_n = 1'b0;
      end
    end
  end

  assign mem_data   = wr_data;
  assign wr_slot    = tail_q;
  assign commit_len = len_n;
  assign commit_err = wr_crc_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      drop_q <= 1'b0;
      len_q  <= '0;
      tail_q <= '0;
    end else begin
      act_q  <= act_n;
      drop_q <= drop_n;
      len_q  <= len_n;
      tail_q <= tail_n;
    end
  end

  // R4
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= CAP);

  // R5
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && drop_q && !(wr_valid && wr_sop)) |-> !mem_we);

endmodule

// File: rtl/iso_rx_rd_ctrl.sv
module iso_rx_rd_ctrl #(
  parameter int SLOT_BYTES = 1024,
  parameter int NSLOT      = 2,
  parameter int AW         = $clog2(SLOT_BYTES),
  parameter int LEN_W      = $clog2(SLOT_BYTES + 1),
  parameter int IDX_W      = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rel_req,
  input  logic [NSLOT-1:0] slot_full,
  input  logic [LEN_W-1:0] head_len,
  output logic [IDX_W-1:0] head,
  output logic [AW-1:0]    rd_addr,
  output logic             rel_pulse
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

  logic [IDX_W-1:0] head_q, head_n;
  logic [LEN_W-1:0] rptr_q, rptr_n;
  logic             ready;

  assign ready = slot_full[head_q];

  always_comb begin
    head_n    = head_q;
    rptr_n    = rptr_q;
    rel_pulse = 1'b0;
    if (rel_req && ready) begin
      rel_pulse = 1'b1;
      head_n    = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
      rptr_n    = '0;
    end else if (rd_en && ready && (rptr_q < head_len)) begin
      rptr_n = rptr_q + 1'b1;
    end
  end

  assign head    = head_q;
  assign rd_addr = rptr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      rptr_q <= '0;
    end else begin
      head_q <= head_n;
      rptr_q <= rptr_n;
    end
  end

  // R3
  rptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (rptr_q <= head_len));

  // R8
  rel_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> (rptr_q == '0));

endmodule

// File: rtl/iso_rx_buffer.sv
module iso_rx_buffer #(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 1024,
  parameter int NSLOT      = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  input  logic                             wr_sop,
  input  logic                             wr_eop,
  input  logic                             wr_crc_err,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             rd_en,
  output logic [DATA_W-1:0]                rd_data,
  output logic [$clog2(SLOT_BYTES+1)-1:0]  rd_len,
  input  logic                             csr_wr,
  input  logic [iso_rx_pkg::ST_W-1:0]      csr_wdata,
  output logic [iso_rx_pkg::ST_W-1:0]      status_o,
  output logic                             irq_o
);

  import iso_rx_pkg::*;

  localparam int AW    = $clog2(SLOT_BYTES);
  localparam int LEN_W = $clog2(SLOT_BYTES + 1);
  localparam int IDX_W = $clog2(NSLOT);

  slot_st_e         st_q   [NSLOT];
  slot_st_e         st_n   [NSLOT];
  logic [LEN_W-1:0] len_q  [NSLOT];
  logic [LEN_W-1:0] len_n  [NSLOT];
  logic [DATA_W-1:0] rdata_s [NSLOT];

  logic [NSLOT-1:0] slot_free, slot_full;
  logic             mem_we, alloc, commit, commit_err, ovr_evt;
  logic [AW-1:0]    mem_addr, rd_addr;
  logic [DATA_W-1:0] mem_data;
  logic [IDX_W-1:0] wr_slot, head;
  logic [LEN_W-1:0] commit_len, head_len;
  logic             rel_req, rel_pulse, ready;
  logic             ovr_q, ovr_n, derr_q, derr_n, irq_q;
  logic             wbit1_unused;

  assign wbit1_unused = csr_wdata[1];

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slot_free[s] = (st_q[s] == SLOT_FREE);
      slot_full[s] = (st_q[s] == SLOT_FULL);
    end
  end

  iso_rx_wr_ctrl #(
    .DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES), .NSLOT(NSLOT),
    .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_crc_err(wr_crc_err), .wr_data(wr_data),
    .slot_free(slot_free),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .wr_slot(wr_slot), .alloc(alloc), .commit(commit),
    .commit_len(commit_len), .commit_err(commit_err), .ovr_evt(ovr_evt)
  );

  assign rel_req  = csr_wr && !csr_wdata[ST_READY];
  assign head_len = len_q[head];

  iso_rx_rd_ctrl #(
    .SLOT_BYTES(SLOT_BYTES), .NSLOT(NSLOT),
    .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rel_req(rel_req),
    .slot_full(slot_full), .head_len(head_len),
    .head(head), .rd_addr(rd_addr), .rel_pulse(rel_pulse)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    iso_rx_slot_mem #(
      .DATA_W(DATA_W), .DEPTH(SLOT_BYTES), .AW(AW)
    ) i_mem (
      .clk(clk),
      .we(mem_we && (wr_slot == IDX_W'(g))),
      .waddr(mem_addr),
      .wdata(mem_data),
      .raddr(rd_addr),
      .rdata(rdata_s[g])
    );
  end

  // Slot occupancy next state
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      st_n[s]  = st_q[s];
      len_n[s] = len_q[s];
      if (alloc && (wr_slot == IDX_W'(s))) begin
        st_n[s] = SLOT_FILL;
      end
      if (commit && (wr_slot == IDX_W'(s))) begin
        st_n[s]  = SLOT_FULL;
        len_n[s] = commit_len;
      end
      if (rel_pulse && (head == IDX_W'(s))) begin
        st_n[s] = SLOT_FREE;
      end
    end
  end

  // Sticky flags next state
  always_comb begin
    ovr_n  = ovr_q;
    derr_n = derr_q;
    if (csr_wr && !csr_wdata[ST_OVERRUN]) ovr_n  = 1'b0;
    if (csr_wr && !csr_wdata[ST_DATAERR]) derr_n = 1'b0;
    if (ovr_evt)               ovr_n  = 1'b1;
    if (commit && commit_err)  derr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        st_q[s]  <= SLOT_FREE;
        len_q[s] <= '0;
      end
      ovr_q  <= 1'b0;
      derr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        st_q[s]  <= st_n[s];
        len_q[s] <= len_n[s];
      end
      ovr_q  <= ovr_n;
      derr_q <= derr_n;
      irq_q  <= commit;
    end
  end

  assign ready    = slot_full[head];
  assign rd_data  = rdata_s[head];
  assign rd_len   = ready ? head_len : '0;
  assign status_o = {derr_q, ovr_q, 1'b0, ready};
  assign irq_o    = irq_q;

  // R5
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status_o[ST_OVERRUN]);

  // R5
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !rel_pulse) |=> (slot_full == $past(slot_full)));

  // R6
  derr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_err) |=> (status_o[ST_DATAERR] && status_o[ST_READY]));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq_o);

  // R2
  ready_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> status_o[ST_READY]);

endmodule

// File: tb/test_iso_rx_buffer.sv
`timescale 1ns/1ps
module test_iso_rx_buffer;

  localparam int CAP   = 16;
  localparam int LEN_W = $clog2(CAP + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_crc_err = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             rd_en = 1'b0;
  logic [7:0]       rd_data;
  logic [LEN_W-1:0] rd_len;
  logic             csr_wr = 1'b0;
  logic [3:0]       csr_wdata = 4'hF;
  logic [3:0]       status_o;
  logic             irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  iso_rx_buffer #(.DATA_W(8), .SLOT_BYTES(CAP), .NSLOT(2)) i_iso_rx_buffer (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_crc_err(wr_crc_err), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_len(rd_len),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .status_o(status_o), .irq_o(irq_o)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_bytes[$];
  int         m_lens[$];
  logic [7:0] m_cur[$];
  int         m_rpos = 0;
  bit         m_open = 0, m_drop = 0;
  bit         m_ovr = 0, m_derr = 0, m_irq = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bytes.delete(); m_lens.delete(); m_cur.delete();
      m_rpos = 0; m_open = 0; m_drop = 0;
      m_ovr = 0; m_derr = 0; m_irq = 0;
    end else begin
      bit rdy, rel, do_commit, ovr_set, derr_set;
      int occ;
      rdy = (m_lens.size() > 0);
      occ = m_lens.size() + ((m_open && !m_drop) ? 1 : 0);
      rel = csr_wr && !csr_wdata[0] && rdy;
      do_commit = 0; ovr_set = 0; derr_set = 0;
      if (!rel && rd_en && rdy && (m_rpos < m_lens[0])) m_rpos++;
      if (wr_valid && wr_sop) begin
        if (m_open && !m_drop) begin
          m_cur.delete(); m_cur.push_back(wr_data);
          if (wr_eop) do_commit = 1;
        end else if (occ < 2) begin
          m_cur.delete(); m_cur.push_back(wr_data);
          m_open = 1; m_drop = 0;
          if (wr_eop) do_commit = 1;
        end else begin
          ovr_set = 1; m_drop = 1; m_open = !wr_eop;
        end
      end else if (wr_valid && m_open) begin
        if (!m_drop) begin
          if (m_cur.size() < CAP) m_cur.push_back(wr_data);
          if (wr_eop) do_commit = 1;
        end else if (wr_eop) begin
          m_open = 0; m_drop = 0;
        end
      end
      m_irq = do_commit;
      if (do_commit) begin
        foreach (m_cur[i]) m_bytes.push_back(m_cur[i]);
        m_lens.push_back(m_cur.size());
        m_cur.delete();
        m_open = 0;
        if (wr_crc_err) derr_set = 1;
      end
      if (rel) begin
        for (int i = 0; i < m_lens[0]; i++) void'(m_bytes.pop_front());
        void'(m_lens.pop_front());
        m_rpos = 0;
      end
      if (csr_wr && !csr_wdata[2]) m_ovr = 0;
      if (csr_wr && !csr_wdata[3]) m_derr = 0;
      if (ovr_set) m_ovr = 1;
      if (derr_set) m_derr = 1;
    end
  end

  // Compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit rdy;
      rdy = (m_lens.size() > 0);
      check("R2 ready",        int'(status_o[0]), int'(rdy));
      check("R2 bit1",         int'(status_o[1]), 0);
      check("R5/R10 overrun",  int'(status_o[2]), int'(m_ovr));
      check("R6/R10 dataerr",  int'(status_o[3]), int'(m_derr));
      check("R7 irq",          int'(irq_o),       int'(m_irq));
      check("R4 rd_len",       int'(rd_len),      rdy ? m_lens[0] : 0);
      if (rdy && m_rpos < m_lens[0])
        check("R3 rd_data", int'(rd_data), int'(m_bytes[m_rpos]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(int len, int base, bit crc);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_sop = (i == 0); wr_eop = (i == len - 1);
      wr_data = 8'(base + i); wr_crc_err = crc && (i == len - 1);
    end
    @(negedge clk);
    wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_crc_err = 0;
  endtask

  task automatic read_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 1;
    end
    @(negedge clk); rd_en = 0;
  endtask

  task automatic csr_write(logic [3:0] d);
    @(negedge clk); csr_wr = 1; csr_wdata = d;
    @(negedge clk); csr_wr = 0; csr_wdata = 4'hF;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R9: reset state
    check("R9 status", int'(status_o), 0);
    check("R9 irq", int'(irq_o), 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R3: reading with nothing held has no effect
    read_n(3);
    check("R9 idle ready", int'(status_o[0]), 0);

    // R2/R3: single packet, read past end, release
    send_pkt(5, 8'h10, 0);
    check("R2 ready set", int'(status_o[0]), 1);
    read_n(8);
    check("R3 read stops", int'(rd_len), 5);
    csr_write(4'b1110);
    check("R8 released", int'(status_o[0]), 0);

    // R1/R5/R8: two packets, third overruns
    send_pkt(4, 8'h40, 0);
    send_pkt(6, 8'h60, 0);
    check("R1 both held len", int'(rd_len), 4);
    send_pkt(3, 8'hA0, 0);
    check("R5 overrun", int'(status_o[2]), 1);
    check("R1 first byte kept", int'(rd_data), 8'h40);
    read_n(2);
    csr_write(4'b1110);
    check("R8 ready stays", int'(status_o[0]), 1);
    check("R8 next len", int'(rd_len), 6);
    check("R8 next byte", int'(rd_data), 8'h60);
    read_n(6);
    csr_write(4'b1110);

    // R10: writing 1 keeps overrun, writing 0 clears it
    csr_write(4'b1111);
    check("R10 keep", int'(status_o[2]), 1);
    csr_write(4'b1011);
    check("R10 clear", int'(status_o[2]), 0);

    // R6: CRC error packet stored and flagged
    send_pkt(3, 8'hC0, 1);
    check("R6 ready", int'(status_o[0]), 1);
    check("R6 dataerr", int'(status_o[3]), 1);
    csr_write(4'b0110);
    check("R6 released/cleared", int'(status_o), 0);

    // R4: oversize packet saturates
    send_pkt(CAP + 4, 8'h00, 0);
    check("R4 saturate", int'(rd_len), CAP);
    read_n(CAP + 2);
    csr_write(4'b1110);

    // R11: restart of an open packet
    @(negedge clk); wr_valid = 1; wr_sop = 1; wr_data = 8'h11;
    @(negedge clk); wr_sop = 0; wr_data = 8'h12;
    @(negedge clk); wr_sop = 1; wr_data = 8'h21;
    @(negedge clk); wr_sop = 0; wr_eop = 1; wr_data = 8'h22;
    @(negedge clk); wr_valid = 0; wr_eop = 0;
    check("R11 restart len", int'(rd_len), 2);
    check("R11 restart byte", int'(rd_data), 8'h21);
    check("R11 no overrun", int'(status_o[2]), 0);

    // R8: release in same cycle as sop with both slots full -> dropped
    send_pkt(2, 8'h30, 0);
    @(negedge clk);
    csr_wr = 1; csr_wdata = 4'b1110;
    wr_valid = 1; wr_sop = 1; wr_eop = 1; wr_data = 8'h77;
    @(negedge clk);
    csr_wr = 0; csr_wdata = 4'hF;
    wr_valid = 0; wr_sop = 0; wr_eop = 0;
    check("R8 same-cycle drop", int'(status_o[2]), 1);
    check("R8 remaining len", int'(rd_len), 2);
    check("R7 no irq on drop", int'(irq_o), 0);
    csr_write(4'b1010);
    idle(3);
    check("R9 empty at end", int'(status_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule